// File: doc/BRIEF.md
# Status LED Driver with Pulse Stretching

This block turns five internal indication signals into five active-low, open-drain LED pad enables. Two of the indications are events (collision and activity). A collision or activity event may last only a few microseconds, which the eye cannot see. The block therefore holds each of these two LEDs on for a programmable number of clock cycles after the event ends. Every new event restarts that hold period from its full length.

The other three indications are levels (link, speed and power). Their LEDs follow the indication directly, one register stage later, and are never stretched. A five-bit stretch-enable input selects, per LED, whether stretching applies. Only the collision and activity bits of that input have any effect. With stretching disabled, an event LED simply follows its input.

Each pad output is an open-drain enable. A 0 means the pad pulls low and the LED is lit. A 1 means the pad is released and the LED is dark. All pads are registered and released during reset.

Top module: `led_indicator_drv`

## Requirements
- R1: While `rst` is high at a clock edge, all five `led_pad_n` bits are 1 after that edge. After reset is released, no stretch from an event before reset remains: an LED whose input is low stays released.
- R2: `led_pad_n` bit positions are fixed: bit 0 collision, bit 1 activity, bit 2 link, bit 3 speed, bit 4 power. A bit value of 0 pulls the pad low (LED lit) and 1 releases it.
- R3: Link, speed and power pads are the inverse of `sts_link`, `sts_speed` and `sts_power` sampled at the previous clock edge, with no stretching.
- R4: When an event input (`evt_col` or `evt_act`) is high at an edge and its stretch enable is 1, its pad is 0 after that edge.
- R5: With stretching enabled, if an event input was last sampled high at edge k, its pad stays 0 after edges k through k+STRETCH_CYC and returns to 1 after edge k+STRETCH_CYC+1. A single-cycle event therefore lights the LED for STRETCH_CYC+1 cycles.
- R6: An event sampled high while a stretch is running restarts the full STRETCH_CYC period from that edge.
- R7: When `stretch_en` bit 0 or bit 1 is 0, that event pad is the inverse of its input sampled at the previous edge. `stretch_en` bits 2 to 4 have no effect on any output.
- R8: The stretch timer of an event channel keeps running while its enable is 0. Setting the enable to 1 in the middle of a window lights the LED for the rest of that window, as timed in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_col | input | 1 | Collision event indication |
| evt_act | input | 1 | Activity event indication |
| sts_link | input | 1 | Link status level |
| sts_speed | input | 1 | Speed status level |
| sts_power | input | 1 | Power status level |
| stretch_en | input | 5 | Per-LED stretch enable, same bit order as `led_pad_n`; only bits 0 and 1 are used |
| led_pad_n | output | 5 | Open-drain enables, 0 = pull low (lit), 1 = released |

## Verification
Several properties are checked on every cycle:
- the released state after reset;
- level pads tracking their inputs with one cycle of delay;
- an enabled event lighting its pad on the next cycle;
- the bypass behaviour when stretching is disabled;
- the timer reloading on every event and counting down by exactly one while idle.

The exact length of a stretch window, the merging of retriggered windows and the partial window seen after a late enable can only be shown by the bench. Its cycle-by-cycle model tracks the edge of the last event and compares all five pads on every clock.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    localparam int unsigned NUM_LEDS = 5;

    typedef enum logic [2:0] {
        LED_COL   = 3'd0,
        LED_ACT   = 3'd1,
        LED_LINK  = 3'd2,
        LED_SPEED = 3'd3,
        LED_POWER = 3'd4
    } led_idx_e;

    typedef enum logic {
        IND_LEVEL = 1'b0,
        IND_EVENT = 1'b1
    } ind_kind_e;

    // Which indications are events (stretchable) and which are levels
    function automatic ind_kind_e kind_of(int unsigned idx);
        if (idx == int'(LED_COL) || idx == int'(LED_ACT))
            return IND_EVENT;
        return IND_LEVEL;
    endfunction

    // Open-drain, active-low pad: lit LED means pad pulled low
    function automatic logic pad_level(logic lit);
        return ~lit;
    endfunction

endpackage

// File: rtl/led_stretch_ch.sv
module led_stretch_ch
    import led_drv_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 10_000_000,
    localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ind,
    input  logic en,
    output logic lit
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYC);

    logic [CNT_W-1:0] cnt;
    logic             active;

    // Timer runs independently of the enable (R8)
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ind)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign active = ind || (cnt != '0);
    assign lit    = en ? active : ind;

    // R6: every event restarts the full period
    a_r6_retrigger: assert property (@(posedge clk) disable iff (rst)
        ind |=> (cnt == RELOAD));

    // R5: an idle running timer counts down by exactly one
    a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
        (!ind && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/led_pad_reg.sv
module led_pad_reg
    import led_drv_pkg::*;
#(
    parameter int unsigned WIDTH = NUM_LEDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lit,
    output logic [WIDTH-1:0] pad_n
);

    always_ff @(posedge clk) begin
        if (rst)
            pad_n <= '1;
        else
            for (int i = 0; i < int'(WIDTH); i++)
                pad_n[i] <= pad_level(lit[i]);
    end

    // R1: reset releases every pad
    a_r1_reset_released: assert property (@(posedge clk)
        rst |=> (pad_n == '1));

endmodule

// File: rtl/led_indicator_drv.sv
module led_indicator_drv
    import led_drv_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 10_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_col,
    input  logic                evt_act,
    input  logic                sts_link,
    input  logic                sts_speed,
    input  logic                sts_power,
    input  logic [NUM_LEDS-1:0] stretch_en,
    output logic [NUM_LEDS-1:0] led_pad_n
);

    logic [NUM_LEDS-1:0] ind_vec;
    logic [NUM_LEDS-1:0] lit_vec;

    // R2: fixed bit positions
    assign ind_vec[LED_COL]   = evt_col;
    assign ind_vec[LED_ACT]   = evt_act;
    assign ind_vec[LED_LINK]  = sts_link;
    assign ind_vec[LED_SPEED] = sts_speed;
    assign ind_vec[LED_POWER] = sts_power;

    for (genvar g = 0; g < int'(NUM_LEDS); g++) begin : g_ch
        if (kind_of(g) == IND_EVENT) begin : g_evt
            led_stretch_ch #(
                .STRETCH_CYC (STRETCH_CYC)
            ) i_stretch (
                .clk (clk),
                .rst (rst),
                .ind (ind_vec[g]),
                .en  (stretch_en[g]),
                .lit (lit_vec[g])
            );
        end else begin : g_lvl
            // R3/R7: level channels ignore their stretch enable
            assign lit_vec[g] = ind_vec[g];
        end
    end

    led_pad_reg #(
        .WIDTH (NUM_LEDS)
    ) i_pads (
        .clk   (clk),
        .rst   (rst),
        .lit   (lit_vec),
        .pad_n (led_pad_n)
    );

    // R3: level pads follow their inputs one cycle later
    a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (led_pad_n[4:2] == ~$past({sts_power, sts_speed, sts_link})));

    // R4: an enabled event lights its pad on the next cycle
    a_r4_col_on: assert property (@(posedge clk) disable iff (rst)
        (evt_col && stretch_en[0]) |=> !led_pad_n[0]);
    a_r4_act_on: assert property (@(posedge clk) disable iff (rst)
        (evt_act && stretch_en[1]) |=> !led_pad_n[1]);

    // R7: disabled stretching gives a plain one-cycle follow
    a_r7_col_bypass: assert property (@(posedge clk) disable iff (rst)
        !stretch_en[0] |=> (led_pad_n[0] == !$past(evt_col)));
    a_r7_act_bypass: assert property (@(posedge clk) disable iff (rst)
        !stretch_en[1] |=> (led_pad_n[1] == !$past(evt_act)));

endmodule

// File: tb/test_led_indicator_drv.sv
`timescale 1ns/1ps
module test_led_indicator_drv;

    localparam int S = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       evt_col, evt_act, sts_link, sts_speed, sts_power;
    logic [4:0] stretch_en;
    logic [4:0] led_pad_n;

    always #2.5 clk = ~clk;

    led_indicator_drv #(.STRETCH_CYC(S)) i_led_indicator_drv (
        .clk        (clk),
        .rst        (rst),
        .evt_col    (evt_col),
        .evt_act    (evt_act),
        .sts_link   (sts_link),
        .sts_speed  (sts_speed),
        .sts_power  (sts_power),
        .stretch_en (stretch_en),
        .led_pad_n  (led_pad_n)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // ---------------- behavioural reference model ----------------
    int         edge_no = 0;
    int         last_hi [2] = '{-1000000, -1000000};
    logic [4:0] exp_pad = '1;
    string      tag [5] = '{"R1", "R1", "R1", "R1", "R1"};
    bit         model_on = 1'b0;

    always @(posedge clk) begin
        logic [4:0] ind;
        edge_no++;
        ind = {sts_power, sts_speed, sts_link, evt_act, evt_col};
        if (rst) begin
            exp_pad = '1;
            last_hi = '{-1000000, -1000000};
            foreach (tag[i]) tag[i] = "R1";
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (i < 2) begin
                    bit on;
                    if (ind[i]) last_hi[i] = edge_no;
                    on = ind[i] || (edge_no - last_hi[i] <= S);
                    if (stretch_en[i]) begin
                        exp_pad[i] = !on;
                        tag[i] = "R5";
                    end else begin
                        exp_pad[i] = !ind[i];
                        tag[i] = "R7";
                    end
                end else begin
                    exp_pad[i] = !ind[i];
                    tag[i] = "R3";
                end
            end
        end
        model_on = 1'b1;
    end

    always @(negedge clk) begin
        if (model_on) begin
            for (int i = 0; i < 5; i++) begin
                n_chk++;
                if (led_pad_n[i] !== exp_pad[i]) begin
                    n_fail++;
                    $display("FAIL %s pad bit %0d at edge %0d: actual %b expected %b",
                             tag[i], i, edge_no, led_pad_n[i], exp_pad[i]);
                end
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise an event for one cycle and count lit cycles on pad b
    task automatic pulse_count(int b, int retrig_gap, output int lit_n);
        lit_n = 0;
        @(negedge clk);
        if (b == 0) evt_col = 1'b1; else evt_act = 1'b1;
        for (int c = 0; c < 4 * S; c++) begin
            @(negedge clk);
            evt_col = 1'b0;
            evt_act = 1'b0;
            if (retrig_gap > 0 && c == retrig_gap - 1) begin
                if (b == 0) evt_col = 1'b1; else evt_act = 1'b1;
            end
            #0.5;
            if (!led_pad_n[b]) lit_n++;
        end
        evt_col = 1'b0;
        evt_act = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        rst = 1'b1;
        evt_col = 1'b0; evt_act = 1'b0;
        sts_link = 1'b1; sts_speed = 1'b1; sts_power = 1'b1;
        stretch_en = 5'b00011;
        idle(3);
        #0.5;
        chk("R1 reset released", int'(led_pad_n), 31);
        @(negedge clk);
        rst = 1'b0;
        sts_link = 1'b0; sts_speed = 1'b0; sts_power = 1'b0;
        idle(2);

        // R5 / R4: single-cycle collision lit for S+1 cycles on bit 0
        pulse_count(0, 0, n);
        chk("R5 single pulse window", n, S + 1);
        // R2: activity uses bit 1
        pulse_count(1, 0, n);
        chk("R2 activity on bit 1", n, S + 1);

        // R6: retrigger after 10 cycles -> one merged window of S+11
        pulse_count(0, 10, n);
        chk("R6 retrigger merged window", n, S + 11);

        // R3: level patterns with stretch enables on level bits toggling (R7)
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {sts_power, sts_speed, sts_link} = 3'(p * 5 + 3);
            stretch_en[4:2] = 3'(p);
        end
        @(negedge clk);
        sts_link = 1'b1; sts_speed = 1'b0; sts_power = 1'b1;
        @(negedge clk);
        #0.5;
        chk("R3 level pattern link/speed/power", int'(led_pad_n[4:2]), 3'b010);
        chk("R2 event pads released while idle", int'(led_pad_n[1:0]), 3);

        // R7: stretching disabled -> one lit cycle
        stretch_en = 5'b00000;
        pulse_count(0, 0, n);
        chk("R7 bypass collision", n, 1);
        pulse_count(1, 0, n);
        chk("R7 bypass activity", n, 1);

        // R8: enable in mid-window shows the remainder
        @(negedge clk);
        evt_col = 1'b1;
        @(negedge clk);
        evt_col = 1'b0;
        idle(4);
        stretch_en[0] = 1'b1;
        n = 0;
        for (int c = 0; c < 3 * S; c++) begin
            @(negedge clk);
            #0.5;
            if (!led_pad_n[0]) n++;
        end
        chk("R8 remaining window after late enable", n, S - 4);

        // R1: reset during a stretch clears it
        stretch_en = 5'b00011;
        @(negedge clk);
        evt_act = 1'b1;
        @(negedge clk);
        evt_act = 1'b0;
        idle(3);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        #0.5;
        chk("R1 no stretch survives reset", int'(led_pad_n[1]), 1);

        // mixed traffic for the per-cycle model
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            evt_col    = ((c % 37) == 0);
            evt_act    = ((c % 7) < 2);
            sts_link   = c[4];
            stretch_en = {3'b000, c[6], ~c[7]};
        end
        evt_col = 1'b0; evt_act = 1'b0;
        idle(3 * S);
        summary();
        $finish;
    end

endmodule